// File: doc/BRIEF.md
# Event number resynchronization matcher

This block serves one input channel of an event builder. Each cycle it sees the event number the trigger side expects next and the event numbers of the first two entries of the channel's header queue. From these it decides how to handle the fragment. It can accept the fragment, discard the fragment at the head of the queue, or stand in an empty block for the expected event and leave the fragment where it is. A mismatch is repaired by discarding or padding wherever a small look-ahead shows how the two streams drifted apart. Loss of sync is declared only when no repair rule fits.

Both queues use a valid/consume handshake. The block drives `exp_ready` to use up the expected number and `frag_pop` to use up the head fragment. The same cycle can consume both of them, only one, or, when no decision is made, neither. Every decision is also registered and shown for one cycle on the decision outputs. The block keeps a short history of the low nibbles of the fragments it has accepted. Three counters record discards, pads and event-number mismatches.

Top module: `evn_resync_matcher`

## Requirements
- R1: A decision is made in a cycle where both `exp_valid` and `head_valid` are high. If `exp_evn` equals `head_evn` the fragment is accepted: `exp_ready` and `frag_pop` are both high, `dec_code` is 2'b00 and `dec_mism` is 0.
- R2: When recovery is enabled, the history is consecutive and the low 4 bits of `exp_evn` and `head_evn` match but the full values differ, the fragment is accepted (both consumed, code 2'b00) with `dec_mism` = 1.
- R3: If neither accept rule applies, the history is consecutive, `next_valid` is high and (`exp_evn` - `next_evn`) mod 2^24 is below 16 (equal included), the head fragment is discarded. Only `frag_pop` is high, code 2'b01 is shown, and `skip_cnt` goes up by one.
- R4: If instead (`next_evn` - `exp_evn`) mod 2^24 lies in 1..15 under the same conditions, an empty block is padded. Only `exp_ready` is high, code 2'b10 is shown, and `pad_cnt` goes up by one.
- R5: Event-number differences wrap modulo 2^24. Expected 0x000002 against next 0xFFFFFF is a distance of 3 back (discard). Expected 0xFFFFFE against next 0x000003 is a distance of 5 ahead (pad).
- R6: When no rule applies, the fragment is accepted as mismatched (both consumed, code 2'b00, `dec_mism` = 1) and `sync_lost` is set. `sync_lost` stays set until reset.
- R7: With `cfg_recover_en` low, the nibble, discard and pad rules are all off. Every mismatch is accepted as in R6, and `skip_cnt` and `pad_cnt` do not change.
- R8: The history holds the low nibbles of the last 3 accepted fragments and is empty after reset. It is consecutive only when it is full and each nibble is one more (mod 16) than the one before it. Without that, R2 to R4 do not apply.
- R9: With `next_valid` low, the discard and pad rules do not apply.
- R10: `mism_cnt` goes up by one for every decision where `exp_evn` differs from `head_evn`. `dec_valid` is high in exactly the cycle after a decision. Without a decision, `exp_ready`, `frag_pop` and `dec_valid` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_recover_en | input | 1 | Enables the nibble, discard and pad rules |
| exp_valid | input | 1 | Expected event number present |
| exp_evn | input | 24 | Expected event number from the trigger record |
| exp_ready | output | 1 | Expected number consumed this cycle |
| head_valid | input | 1 | Header queue head present |
| head_evn | input | 24 | Event number of the head fragment |
| next_valid | input | 1 | Second queue entry present |
| next_evn | input | 24 | Event number of the second queue entry |
| frag_pop | output | 1 | Head fragment consumed this cycle |
| dec_valid | output | 1 | Registered decision strobe |
| dec_code | output | 2 | 00 accept, 01 discard, 10 pad |
| dec_mism | output | 1 | Decision had unequal event numbers |
| sync_lost | output | 1 | Sticky: a mismatch was accepted with no rule |
| skip_cnt | output | 16 | Discarded fragments |
| pad_cnt | output | 16 | Padded blocks |
| mism_cnt | output | 16 | Decisions with unequal event numbers |

## Verification
The bench builds the nibble history on purpose and then breaks it. It sends a nibble match and a look-ahead that is in range while the history has a gap. A design that skipped the history check would pad or accept quietly there instead of raising `sync_lost`. It tests the zero-distance discard, the distance-15 and distance-16 edges, and both directions of the 2^24 wrap, which catch a signed compare or a missing wrap. It also runs with recovery disabled and with `next_valid` low, where a design that still took a look-ahead rule would change `skip_cnt` or `pad_cnt` or consume only one side.

// File: rtl/evn_resync_pkg.sv
package evn_resync_pkg;
  localparam int EVN_W  = 24;
  localparam int NIB_W  = 4;
  localparam int HIST_N = 3;
  localparam int WINDOW = 16;

  typedef logic [EVN_W-1:0] evn_t;
  typedef logic [NIB_W-1:0] nib_t;

  typedef enum logic [1:0] {
    DEC_ACCEPT = 2'b00,
    DEC_SKIP   = 2'b01,
    DEC_PAD    = 2'b10
  } dec_e;

  // Distance a - b, wrapping at 2^EVN_W
  function automatic evn_t evn_diff(input evn_t a, input evn_t b);
    return a - b;
  endfunction

  function automatic logic in_window(input evn_t d);
    return d < evn_t'(WINDOW);
  endfunction

  function automatic nib_t nib_of(input evn_t e);
    return e[NIB_W-1:0];
  endfunction

  // b follows a by one, modulo 2^NIB_W
  function automatic logic steps_up(input nib_t a, input nib_t b);
    return b == nib_t'(a + nib_t'(1));
  endfunction
endpackage

// File: rtl/evn_nibble_history.sv
module evn_nibble_history
  import evn_resync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  nib_t din,
  output logic consec
);
  localparam int FILL_W = $clog2(HIST_N + 1);

  nib_t [HIST_N-1:0]  hist;
  logic [FILL_W-1:0]  fill;
  logic [HIST_N-2:0]  step_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      fill <= '0;
    end else if (push) begin
      hist[0] <= din;
      if (fill != FILL_W'(HIST_N)) fill <= fill + FILL_W'(1);
      for (int i = 1; i < HIST_N; i++) hist[i] <= hist[i-1];
    end
  end

  // hist[0] is the newest entry
  for (genvar g = 0; g < HIST_N - 1; g++) begin : g_step
    assign step_ok[g] = steps_up(hist[g+1], hist[g]);
  end

  assign consec = (fill == FILL_W'(HIST_N)) && (&step_ok);

  // R8
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(HIST_N));

  // R8
  fill_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(fill));
endmodule

// File: rtl/evn_resync_decide.sv
module evn_resync_decide
  import evn_resync_pkg::*;
(
  input  logic recover_en,
  input  logic hist_consec,
  input  logic next_valid,
  input  evn_t exp_evn,
  input  evn_t head_evn,
  input  evn_t next_evn,
  output dec_e code,
  output logic full_match,
  output logic nib_hit,
  output logic skip_hit,
  output logic pad_hit,
  output logic no_rule
);
  evn_t back_d;
  evn_t fwd_d;
  logic rules_on;
  logic look_on;

  always_comb begin
    back_d     = evn_diff(exp_evn, next_evn);
    fwd_d      = evn_diff(next_evn, exp_evn);
    rules_on   = recover_en && hist_consec;
    look_on    = rules_on && next_valid;
    full_match = (exp_evn == head_evn);
    nib_hit    = !full_match && rules_on && (nib_of(exp_evn) == nib_of(head_evn));
    skip_hit   = !full_match && !nib_hit && look_on && in_window(back_d);
    pad_hit    = !full_match && !nib_hit && !skip_hit && look_on && in_window(fwd_d);
    no_rule    = !full_match && !nib_hit && !skip_hit && !pad_hit;
    if (skip_hit)     code = DEC_SKIP;
    else if (pad_hit) code = DEC_PAD;
    else              code = DEC_ACCEPT;
  end
endmodule

// File: rtl/evn_event_counters.sv
module evn_event_counters #(
  parameter int N     = 3,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              inc,
  output logic [N-1:0][CNT_W-1:0]   cnt
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)      cnt[g] <= '0;
      else if (inc[g]) cnt[g] <= cnt[g] + CNT_W'(1);
    end

    // R10 R3 R4: a counter moves by at most one per decision
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inc[g] |=> $stable(cnt[g]));
  end
endmodule

// File: rtl/evn_resync_matcher.sv
module evn_resync_matcher
  import evn_resync_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_recover_en,
  input  logic             exp_valid,
  input  logic [EVN_W-1:0] exp_evn,
  output logic             exp_ready,
  input  logic             head_valid,
  input  logic [EVN_W-1:0] head_evn,
  input  logic             next_valid,
  input  logic [EVN_W-1:0] next_evn,
  output logic             frag_pop,
  output logic             dec_valid,
  output logic [1:0]       dec_code,
  output logic             dec_mism,
  output logic             sync_lost,
  output logic [CNT_W-1:0] skip_cnt,
  output logic [CNT_W-1:0] pad_cnt,
  output logic [CNT_W-1:0] mism_cnt
);
  localparam int N_CNT = 3;

  logic fire;
  dec_e code;
  logic full_match, nib_hit, skip_hit, pad_hit, no_rule;
  logic hist_consec;
  logic accept_ev, skip_ev, pad_ev, lost_ev, mism_ev;
  logic [N_CNT-1:0]            cnt_inc;
  logic [N_CNT-1:0][CNT_W-1:0] cnt_val;

  assign fire = exp_valid && head_valid;

  evn_resync_decide u_decide (
    .recover_en (cfg_recover_en),
    .hist_consec(hist_consec),
    .next_valid (next_valid),
    .exp_evn    (exp_evn),
    .head_evn   (head_evn),
    .next_evn   (next_evn),
    .code       (code),
    .full_match (full_match),
    .nib_hit    (nib_hit),
    .skip_hit   (skip_hit),
    .pad_hit    (pad_hit),
    .no_rule    (no_rule)
  );

  // Named decision events
  assign accept_ev = fire && (code == DEC_ACCEPT);
  assign skip_ev   = fire && skip_hit;
  assign pad_ev    = fire && pad_hit;
  assign lost_ev   = fire && no_rule;
  assign mism_ev   = fire && !full_match;

  assign exp_ready = fire && (code != DEC_SKIP);
  assign frag_pop  = fire && (code != DEC_PAD);

  evn_nibble_history u_hist (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept_ev),
    .din   (nib_of(head_evn)),
    .consec(hist_consec)
  );

  assign cnt_inc = {mism_ev, pad_ev, skip_ev};

  evn_event_counters #(.N(N_CNT), .CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (cnt_inc),
    .cnt  (cnt_val)
  );

  assign skip_cnt = cnt_val[0];
  assign pad_cnt  = cnt_val[1];
  assign mism_cnt = cnt_val[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_code  <= DEC_ACCEPT;
      dec_mism  <= 1'b0;
      sync_lost <= 1'b0;
    end else begin
      dec_valid <= fire;
      if (fire) begin
        dec_code <= code;
        dec_mism <= !full_match;
      end
      if (lost_ev) sync_lost <= 1'b1;
    end
  end

  // R1
  full_match_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && exp_evn == head_evn) |-> (exp_ready && frag_pop));

  // R7
  disabled_both_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cfg_recover_en) |-> (exp_ready && frag_pop));

  // R9
  no_lookahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !next_valid) |-> (exp_ready && frag_pop));

  // R3
  skip_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && exp_ready == 1'b0) |=> (skip_cnt == $past(skip_cnt) + CNT_W'(1)));

  // R4
  pad_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && frag_pop == 1'b0) |=> (pad_cnt == $past(pad_cnt) + CNT_W'(1)));

  // R6
  sync_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(sync_lost));

  // R10
  no_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |-> (!exp_ready && !frag_pop));

  // R10
  strobe_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !dec_valid);
endmodule

// File: tb/evn_resync_matcher_tb.sv
`timescale 1ns/100ps
module evn_resync_matcher_tb;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_recover_en = 1'b1;
  logic exp_valid = 1'b0, head_valid = 1'b0, next_valid = 1'b0;
  logic [23:0] exp_evn = '0, head_evn = '0, next_evn = '0;
  logic exp_ready, frag_pop, dec_valid, dec_mism, sync_lost;
  logic [1:0] dec_code;
  logic [CW-1:0] skip_cnt, pad_cnt, mism_cnt;

  always #2.5 clk = ~clk;

  evn_resync_matcher #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_recover_en(cfg_recover_en),
    .exp_valid(exp_valid), .exp_evn(exp_evn), .exp_ready(exp_ready),
    .head_valid(head_valid), .head_evn(head_evn),
    .next_valid(next_valid), .next_evn(next_evn), .frag_pop(frag_pop),
    .dec_valid(dec_valid), .dec_code(dec_code), .dec_mism(dec_mism),
    .sync_lost(sync_lost), .skip_cnt(skip_cnt), .pad_cnt(pad_cnt),
    .mism_cnt(mism_cnt)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    string tag;
    int code;
    int mism;
    int skips;
    int pads;
    int mms;
    int lost;
  } item_t;

  item_t sb[$];

  // Bench reference state
  int m_hist[$];
  int m_skip = 0, m_pad = 0, m_mism = 0, m_lost = 0;

  task automatic chk(string tag, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic bit run_ok();
    int s = m_hist.size();
    if (s < 3) return 0;
    return (((m_hist[s-3] + 1) % 16) == m_hist[s-2]) &&
           (((m_hist[s-2] + 1) % 16) == m_hist[s-1]);
  endfunction

  // Drive one decision; check the handshake and queue the expected result
  task automatic step(string tag, int e, int h, int n, bit nv);
    item_t it;
    int back, fwd, code, mm;
    bit ok, lost;
    @(negedge clk);
    exp_valid = 1; head_valid = 1; next_valid = nv;
    exp_evn = e[23:0]; head_evn = h[23:0]; next_evn = n[23:0];
    back = (e - n) & 24'hFFFFFF;
    fwd  = (n - e) & 24'hFFFFFF;
    ok   = cfg_recover_en && run_ok();
    lost = 0;
    mm   = (e != h);
    if (e == h) code = 0;
    else if (ok && (e % 16) == (h % 16)) code = 0;
    else if (ok && nv && back < 16) code = 1;
    else if (ok && nv && fwd < 16) code = 2;
    else begin code = 0; lost = 1; end
    if (code == 0) begin
      m_hist.push_back(h % 16);
      if (m_hist.size() > 3) void'(m_hist.pop_front());
    end
    if (code == 1) m_skip++;
    if (code == 2) m_pad++;
    if (mm) m_mism++;
    if (lost) m_lost = 1;
    #1;
    chk({tag, " exp_ready"}, int'(exp_ready), int'(code != 1));
    chk({tag, " frag_pop"}, int'(frag_pop), int'(code != 2));
    it.tag = tag; it.code = code; it.mism = mm; it.skips = m_skip;
    it.pads = m_pad; it.mms = m_mism; it.lost = m_lost;
    sb.push_back(it);
  endtask

  task automatic idle(string tag, bit ev, bit hv);
    @(negedge clk);
    exp_valid = ev; head_valid = hv; next_valid = 1;
    #1;
    chk({tag, " idle exp_ready"}, int'(exp_ready), 0);
    chk({tag, " idle frag_pop"}, int'(frag_pop), 0);
  endtask

  // Monitor: pop and compare on every decision strobe
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (rst_n && dec_valid) begin
        if (sb.size() == 0) begin
          chk("R10 unexpected dec_valid", 1, 0);
        end else begin
          it = sb.pop_front();
          chk({it.tag, " dec_code"}, int'(dec_code), it.code);
          chk({it.tag, " dec_mism"}, int'(dec_mism), it.mism);
          chk({it.tag, " skip_cnt"}, int'(skip_cnt), it.skips);
          chk({it.tag, " pad_cnt"}, int'(pad_cnt), it.pads);
          chk({it.tag, " mism_cnt R10"}, int'(mism_cnt), it.mms);
          chk({it.tag, " sync_lost"}, int'(sync_lost), it.lost);
        end
      end else if (rst_n && sb.size() != 0 && !exp_valid) begin
        chk("R10 missing dec_valid", 0, 1);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset dec_valid", int'(dec_valid), 0);
    chk("R6 reset sync_lost", int'(sync_lost), 0);
    chk("R10 reset mism_cnt", int'(mism_cnt), 0);
    chk("R3 reset skip_cnt", int'(skip_cnt), 0);

    // R8: before the history fills, a nibble match is not enough
    step("R8 empty history", 'h20, 'h10, 'h21, 1);   // nibble 0 vs 0, no run -> lost
    // seed the history 0,1,2
    step("R1 seed a", 'h10, 'h10, 'h11, 1);
    step("R1 seed b", 'h11, 'h11, 'h12, 1);
    step("R1 seed c", 'h12, 'h12, 'h13, 1);
    step("R2 nibble accept", 'h13, 'h100013, 'h14, 1);
    step("R3 skip smaller", 'h14, 'h77, 'h12, 1);
    step("R3 skip equal", 'h14, 'h78, 'h14, 1);
    step("R1 after skip", 'h14, 'h14, 'h15, 1);
    step("R4 pad one", 'h15, 'h17, 'h18, 1);
    step("R4 pad two", 'h16, 'h17, 'h18, 1);
    step("R1 after pad", 'h17, 'h17, 'h18, 1);
    // history 3,4,7 has a gap
    step("R8 gap blocks pad", 'h18, 'h28, 'h19, 1);
    step("R1 reseed a", 'h19, 'h19, 'h1A, 1);
    step("R1 reseed b", 'h1A, 'h1A, 'h1B, 1);
    step("R1 reseed c", 'h1B, 'h1B, 'h1C, 1);
    step("R4 edge 15", 'h1C, 'h1D, 'h2B, 1);
    step("R6 edge 16", 'h1C, 'h1D, 'h2C, 1);
    step("R1 reseed d", 'h1E, 'h1E, 'h1F, 1);
    step("R1 reseed e", 'h1F, 'h1F, 'h20, 1);
    step("R1 reseed f", 'h20, 'h20, 'h21, 1);
    step("R5 wrap skip", 'h000002, 'h500000, 'hFFFFFF, 1);
    step("R5 wrap pad", 'hFFFFFE, 'h000007, 'h000003, 1);
    step("R1 reseed g", 'h3, 'h3, 'h4, 1);
    step("R1 reseed h", 'h4, 'h4, 'h5, 1);
    step("R1 reseed i", 'h5, 'h5, 'h6, 1);
    step("R9 no next", 'h6, 'h99, 'h6, 0);
    step("R1 reseed j", 'h7, 'h7, 'h8, 1);
    step("R1 reseed k", 'h8, 'h8, 'h9, 1);
    step("R1 reseed l", 'h9, 'h9, 'hA, 1);
    cfg_recover_en = 0;
    step("R7 disabled nibble", 'hA, 'h3A, 'hB, 1);
    step("R7 disabled skip", 'hB, 'h44, 'hB, 1);
    step("R7 disabled pad", 'hC, 'h44, 'hD, 1);
    cfg_recover_en = 1;
    idle("R10 exp only", 1, 0);
    idle("R10 head only", 0, 1);
    @(negedge clk);
    chk("R10 no strobe without decision", int'(dec_valid), 0);
    exp_valid = 0; head_valid = 0;
    repeat (4) @(negedge clk);
    chk("R10 scoreboard drained", sb.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule